// File: doc/BRIEF.md
# PLL Feedback Multiplier Ramp Controller

This block changes only the feedback multiplier N of a running PLL, letting the PLL's own ramp hardware move the VCO gradually so that lock is not lost. A request carries the new N together with the coefficient word currently in force. The controller first puts the PLL into slowdown. After a one-microsecond settle it writes the coefficient word back with only the N field replaced. After a second settle it enables the dynamic ramp. It then waits, for a bounded time, for a synchronized ramp-done status. Finally it drops both control bits, issues a readback strobe and signals completion. If the ramp-done status never arrives, the exit still happens and a timeout error is flagged.

A small table also turns the reference clock rate (given in kHz) into the two ramp step constants the ramp hardware needs. A reference outside the supported set is rejected: any request made with it completes at once with an error and no writes. A request whose N already matches the current N also completes at once with no writes. Delays are counted in clock cycles, using a parameter that gives the number of cycles per microsecond.

The state machine has eight states: IDLE, SETTLE_PRE (slowdown held, first settle), LOAD (one-cycle coefficient write), SETTLE_POST (second settle), POLL (ramp enabled, waiting), LEAVE (both controls cleared), READBACK (readback strobe) and FINISH (done pulse). The transitions are:
- IDLE to FINISH on a start with a rejected reference or an unchanged N.
- IDLE to SETTLE_PRE on any other start.
- SETTLE_PRE to LOAD when the settle count expires.
- LOAD to SETTLE_POST unconditionally.
- SETTLE_POST to POLL when the settle count expires.
- POLL to LEAVE on ramp-done or when the poll limit is reached.
- LEAVE to READBACK, READBACK to FINISH and FINISH to IDLE, each unconditionally.

Top module: `ndiv_ramp_ctrl`

## Requirements
- R1: After reset, busy, done, slowdown, ramp_en, coeff_we and rd_strobe are all low.
- R2: A start whose req_n equals the N field of cur_coeff raises done in the first cycle after the start is sampled, and never raises slowdown or coeff_we.
- R3: On an accepted change request, slowdown goes high in the first cycle after the start is sampled and stays high for exactly CYC_PER_US*SETTLE_US cycles before coeff_we.
- R4: coeff_we is high for exactly one cycle per request. coeff_wdata is cur_coeff with bits [N_W+M_W-1:M_W] (the N field) replaced by req_n. The M field in bits [M_W-1:0], the PL field above N, and all higher bits are unchanged.
- R5: ramp_en first goes high CYC_PER_US*SETTLE_US+1 cycles after the coeff_we cycle, while slowdown is still high.
- R6: When ramp_done_sync is high during a cycle with ramp_en high, slowdown and ramp_en are both low in the next cycle. rd_strobe follows one cycle later, then done one cycle after that, with timeout_err low.
- R7: If ramp_done_sync stays low, ramp_en stays high for exactly CYC_PER_US*POLL_US cycles. Both controls are then cleared, and done arrives two cycles later with timeout_err high.
- R8: The step table gives step_a/step_b = 0x2B/0x0B for ref_khz 12000, 12800 and 13000; 0x12/0x08 for 19200; and 0x04/0x05 for 38400, each with ref_ok high. Any other value gives ref_ok low and zero steps. A start made with it completes in one cycle with ref_err high and no writes.
- R9: A start asserted while busy is high is ignored: the write in progress keeps its data and no second write occurs.
- R10: timeout_err and ref_err are cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| req_n | input | N_W | Requested feedback multiplier |
| cur_coeff | input | COEFF_W | Coefficient word currently in force |
| ref_khz | input | REF_W | Reference clock rate in kHz |
| ramp_done_sync | input | 1 | Synchronized ramp-complete status |
| step_a | output | 8 | First ramp step constant for this reference |
| step_b | output | 8 | Second ramp step constant for this reference |
| ref_ok | output | 1 | Reference rate is supported |
| coeff_we | output | 1 | Coefficient word write strobe |
| coeff_wdata | output | COEFF_W | Coefficient word to write |
| slowdown | output | 1 | Slowdown-using-PLL control |
| ramp_en | output | 1 | Dynamic ramp enable |
| rd_strobe | output | 1 | Readback strobe after the controls are cleared |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Last request ended without ramp-done |
| ref_err | output | 1 | Last request was rejected for its reference |

## Verification
A state register that advances early or late shows up at once as a slowdown, write or ramp-enable edge that falls in the wrong cycle. The bench therefore timestamps each of these edges against the start cycle and compares them cycle-exactly. A poll counter that is cleared wrongly shows up as a ramp_en window that differs from the programmed length, which the timeout scenario measures directly. A lost or stale flag register only shows up at the next done pulse, so each flag is checked at done across consecutive requests.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_SETTLE_PRE  = 3'd1,
        ST_LOAD        = 3'd2,
        ST_SETTLE_POST = 3'd3,
        ST_POLL        = 3'd4,
        ST_LEAVE       = 3'd5,
        ST_READBACK    = 3'd6,
        ST_FINISH      = 3'd7
    } ramp_state_t;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
    } step_pair_t;

endpackage

// File: rtl/ramp_step_table.sv
module ramp_step_table
    import ramp_pkg::*;
#(
    parameter int REF_W = 16
) (
    input  logic [REF_W-1:0] ref_khz,
    output step_pair_t       steps,
    output logic             ok
);
    always_comb begin
        ok    = 1'b1;
        steps = '0;
        unique case (ref_khz)
            REF_W'(12000), REF_W'(12800), REF_W'(13000): steps = '{a: 8'h2B, b: 8'h0B};
            REF_W'(19200): steps = '{a: 8'h12, b: 8'h08};
            REF_W'(38400): steps = '{a: 8'h04, b: 8'h05};
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/ramp_cycle_timer.sv
module ramp_cycle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || clear)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign expired = run && (cnt_q == (limit - CNT_W'(1)));
endmodule

// File: rtl/ndiv_ramp_ctrl.sv
module ndiv_ramp_ctrl
    import ramp_pkg::*;
#(
    parameter int CYC_PER_US = 200,
    parameter int SETTLE_US  = 1,
    parameter int POLL_US    = 500,
    parameter int M_W        = 8,
    parameter int N_W        = 8,
    parameter int PL_W       = 6,
    parameter int COEFF_W    = 32,
    parameter int REF_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [N_W-1:0]     req_n,
    input  logic [COEFF_W-1:0] cur_coeff,
    input  logic [REF_W-1:0]   ref_khz,
    input  logic               ramp_done_sync,
    output logic [7:0]         step_a,
    output logic [7:0]         step_b,
    output logic               ref_ok,
    output logic               coeff_we,
    output logic [COEFF_W-1:0] coeff_wdata,
    output logic               slowdown,
    output logic               ramp_en,
    output logic               rd_strobe,
    output logic               busy,
    output logic               done,
    output logic               timeout_err,
    output logic               ref_err
);
    localparam int N_LSB      = M_W;
    localparam int PL_LSB     = M_W + N_W;
    localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
    localparam int POLL_CYC   = CYC_PER_US * POLL_US;
    localparam int MAX_CYC    = (POLL_CYC > SETTLE_CYC) ? POLL_CYC : SETTLE_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    // The coefficient word must hold all three fields.
    if (PL_LSB + PL_W > COEFF_W) begin : g_bad_layout
        initial $error("coefficient fields exceed COEFF_W");
    end

    ramp_state_t        state_q, state_d;
    step_pair_t         steps;
    logic               tmr_run, tmr_clear, tmr_exp;
    logic [CNT_W-1:0]   tmr_limit;
    logic [COEFF_W-1:0] word_q, word_next;
    logic               tmo_q, referr_q;
    logic               same_n;

    ramp_step_table #(.REF_W(REF_W)) u_steps (
        .ref_khz (ref_khz),
        .steps   (steps),
        .ok      (ref_ok)
    );

    assign step_a = steps.a;
    assign step_b = steps.b;

    ramp_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .clear   (tmr_clear),
        .limit   (tmr_limit),
        .expired (tmr_exp)
    );

    assign same_n = (req_n == cur_coeff[N_LSB +: N_W]);

    always_comb begin
        word_next               = cur_coeff;
        word_next[N_LSB +: N_W] = req_n;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!ref_ok || same_n) state_d = ST_FINISH;
                    else                   state_d = ST_SETTLE_PRE;
                end
            end
            ST_SETTLE_PRE:  if (tmr_exp) state_d = ST_LOAD;
            ST_LOAD:        state_d = ST_SETTLE_POST;
            ST_SETTLE_POST: if (tmr_exp) state_d = ST_POLL;
            ST_POLL:        if (ramp_done_sync || tmr_exp) state_d = ST_LEAVE;
            ST_LEAVE:       state_d = ST_READBACK;
            ST_READBACK:    state_d = ST_FINISH;
            ST_FINISH:      state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    assign tmr_run   = (state_q == ST_SETTLE_PRE) || (state_q == ST_SETTLE_POST) ||
                       (state_q == ST_POLL);
    assign tmr_clear = (state_d != state_q);
    assign tmr_limit = (state_q == ST_POLL) ? CNT_W'(POLL_CYC) : CNT_W'(SETTLE_CYC);

    // State and captured-request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            word_q   <= '0;
            tmo_q    <= 1'b0;
            referr_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                word_q   <= word_next;
                tmo_q    <= 1'b0;
                referr_q <= !ref_ok;
            end
            if (state_q == ST_POLL && state_d == ST_LEAVE && !ramp_done_sync)
                tmo_q <= 1'b1;
        end
    end

    // Output decode
    always_comb begin
        slowdown  = 1'b0;
        ramp_en   = 1'b0;
        coeff_we  = 1'b0;
        rd_strobe = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:        ;
            ST_SETTLE_PRE:  slowdown = 1'b1;
            ST_LOAD:        begin slowdown = 1'b1; coeff_we = 1'b1; end
            ST_SETTLE_POST: slowdown = 1'b1;
            ST_POLL:        begin slowdown = 1'b1; ramp_en = 1'b1; end
            ST_LEAVE:       ;
            ST_READBACK:    rd_strobe = 1'b1;
            ST_FINISH:      done = 1'b1;
            default:        ;
        endcase
    end

    assign busy        = (state_q != ST_IDLE);
    assign coeff_wdata = word_q;
    assign timeout_err = tmo_q;
    assign ref_err     = referr_q;
endmodule

// File: rtl/ramp_ctrl_chk.sv
module ramp_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic slowdown,
    input logic ramp_en,
    input logic coeff_we,
    input logic rd_strobe,
    input logic done,
    input logic busy,
    input logic timeout_err
);
    // R5
    ramp_under_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_en |-> slowdown);

    // R4
    write_in_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coeff_we |-> (slowdown && !ramp_en));

    // R4
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coeff_we |=> !coeff_we);

    // R6
    joint_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ramp_en) |-> !slowdown);

    // R6
    readback_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> done);

    // R7
    timeout_after_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (!slowdown && !ramp_en));

    // R1
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind ndiv_ramp_ctrl ramp_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slowdown    (slowdown),
    .ramp_en     (ramp_en),
    .coeff_we    (coeff_we),
    .rd_strobe   (rd_strobe),
    .done        (done),
    .busy        (busy),
    .timeout_err (timeout_err)
);

// File: tb/sim_ndiv_ramp_ctrl.sv
`timescale 1ns/1ps
module sim_ndiv_ramp_ctrl;
    localparam int CPU = 4;
    localparam int L   = CPU * 1;
    localparam int P   = CPU * 500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  req_n = '0;
    logic [31:0] cur_coeff = '0;
    logic [15:0] ref_khz = 16'd19200;
    logic        ramp_done_sync = 1'b0;
    logic [7:0]  step_a, step_b;
    logic        ref_ok, coeff_we, slowdown, ramp_en, rd_strobe;
    logic        busy, done, timeout_err, ref_err;
    logic [31:0] coeff_wdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int t_slow, t_we, t_ramp, t_exit, t_rd, t_done, n_we, ramp_cycles, n_slow;
    logic [31:0] we_data;
    logic tmo_seen, rerr_seen;

    always #2.5ns clk = ~clk;

    ndiv_ramp_ctrl #(.CYC_PER_US(CPU), .SETTLE_US(1), .POLL_US(500)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .req_n(req_n),
        .cur_coeff(cur_coeff), .ref_khz(ref_khz), .ramp_done_sync(ramp_done_sync),
        .step_a(step_a), .step_b(step_b), .ref_ok(ref_ok),
        .coeff_we(coeff_we), .coeff_wdata(coeff_wdata),
        .slowdown(slowdown), .ramp_en(ramp_en), .rd_strobe(rd_strobe),
        .busy(busy), .done(done), .timeout_err(timeout_err), .ref_err(ref_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issues one request and timestamps every output event relative to it.
    task automatic run_op(input logic [7:0] rq, input logic [31:0] cw,
                          input logic [15:0] rk, input int ack_after, input bit poke);
        t_slow = -1; t_we = -1; t_ramp = -1; t_exit = -1; t_rd = -1; t_done = -1;
        n_we = 0; ramp_cycles = 0; n_slow = 0; we_data = '0;
        tmo_seen = 1'b0; rerr_seen = 1'b0;
        @(negedge clk);
        req_n = rq; cur_coeff = cw; ref_khz = rk; ramp_done_sync = 1'b0;
        start = 1'b1;
        for (int t = 1; t <= P + 200; t++) begin
            @(negedge clk);
            if (t == 1) start = 1'b0;
            if (poke && t == 2) begin start = 1'b1; req_n = rq ^ 8'h55; end
            if (poke && t == 3) begin start = 1'b0; req_n = rq; end
            if (slowdown) begin
                n_slow++;
                if (t_slow < 0) t_slow = t;
            end
            if (coeff_we) begin
                n_we++; we_data = coeff_wdata;
                if (t_we < 0) t_we = t;
            end
            if (ramp_en) begin
                ramp_cycles++;
                if (t_ramp < 0) t_ramp = t;
                if (ack_after > 0 && ramp_cycles == ack_after) ramp_done_sync = 1'b1;
            end
            if (t_slow >= 0 && !slowdown && t_exit < 0) t_exit = t;
            if (rd_strobe && t_rd < 0) t_rd = t;
            if (done) begin
                t_done = t; tmo_seen = timeout_err; rerr_seen = ref_err;
                break;
            end
        end
        ramp_done_sync = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_reset();
        chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
        chk(!slowdown && !ramp_en && !coeff_we && !rd_strobe, "R1 controls",
            {slowdown, ramp_en, coeff_we, rd_strobe}, 0);
    endtask

    task automatic test_table();
        logic [15:0] refs [6] = '{16'd12000, 16'd12800, 16'd13000, 16'd19200, 16'd38400, 16'd25000};
        logic [16:0] exp  [6] = '{17'h12B0B, 17'h12B0B, 17'h12B0B, 17'h11208, 17'h10405, 17'h00000};
        for (int i = 0; i < 6; i++) begin
            ref_khz = refs[i];
            #1;
            chk({ref_ok, step_a, step_b} == exp[i], "R8 step table",
                {ref_ok, step_a, step_b}, exp[i]);
        end
        ref_khz = 16'd19200;
    endtask

    task automatic test_normal();
        run_op(8'h48, 32'hA52A3011, 16'd19200, 3, 1'b0);
        chk(t_slow == 1, "R3 slowdown first", t_slow, 1);
        chk(t_we - t_slow == L, "R3 first settle", t_we - t_slow, L);
        chk(n_we == 1, "R4 one write", n_we, 1);
        chk(we_data == 32'hA52A4811, "R4 write data", we_data, 32'hA52A4811);
        chk(t_ramp - t_we == L + 1, "R5 ramp enable timing", t_ramp - t_we, L + 1);
        chk(t_exit == t_ramp + 3, "R6 exit after ramp-done", t_exit, t_ramp + 3);
        chk(t_rd == t_exit + 1, "R6 readback", t_rd, t_exit + 1);
        chk(t_done == t_exit + 2, "R6 done", t_done, t_exit + 2);
        chk(!tmo_seen, "R6 no timeout", tmo_seen, 0);
    endtask

    task automatic test_timeout();
        run_op(8'h20, 32'h00153011, 16'd38400, -1, 1'b0);
        chk(ramp_cycles == P, "R7 poll window", ramp_cycles, P);
        chk(t_exit == t_ramp + P, "R7 exit on timeout", t_exit, t_ramp + P);
        chk(t_done == t_exit + 2, "R7 done", t_done, t_exit + 2);
        chk(tmo_seen, "R7 timeout flag", tmo_seen, 1);
        run_op(8'h31, 32'h00152011, 16'd38400, 1, 1'b0);
        chk(!tmo_seen, "R10 timeout cleared", tmo_seen, 0);
        chk(t_exit == t_ramp + 1, "R6 immediate ramp-done", t_exit, t_ramp + 1);
    endtask

    task automatic test_equal();
        run_op(8'h30, 32'h00153011, 16'd12800, 2, 1'b0);
        chk(t_done == 1, "R2 immediate done", t_done, 1);
        chk(n_we == 0 && t_slow < 0, "R2 no writes", n_we, 0);
    endtask

    task automatic test_badref();
        run_op(8'h40, 32'h00153011, 16'd25000, 2, 1'b0);
        chk(t_done == 1, "R8 rejected done", t_done, 1);
        chk(rerr_seen, "R8 ref_err", rerr_seen, 1);
        chk(n_we == 0 && t_slow < 0, "R8 no writes", n_we, 0);
        run_op(8'h40, 32'h00153011, 16'd13000, 2, 1'b0);
        chk(!rerr_seen, "R10 ref_err cleared", rerr_seen, 0);
        chk(n_we == 1, "R10 accepted after reject", n_we, 1);
    endtask

    task automatic test_busy_start();
        run_op(8'h66, 32'h3F0A1105, 16'd12000, 2, 1'b1);
        chk(n_we == 1, "R9 no second write", n_we, 1);
        chk(we_data == 32'h3F0A6605, "R9 data kept", we_data, 32'h3F0A6605);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_table();
        test_normal();
        test_timeout();
        test_equal();
        test_badref();
        test_busy_start();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule